// File: doc/BRIEF.md
# Transition-Encoded Isolation Link Transmitter

This block drives a narrow link that carries several single-bit logic lanes as discrete events instead of levels. Each lane input is synchronized to the local clock. Any change in the synchronized level, measured against the last level the block sent, produces a one-cycle event on that lane. The event is either "now high" or "now low". The receiving side rebuilds each level from these events alone.

A receiver can lose its state after a fault or at power-up, so a background scheduler resends the held level of any lane that has stayed quiet for a full refresh period. Refresh events are granted round-robin across lanes, with at most one per cycle. A real edge on a lane always wins over that lane's refresh and restarts its quiet timer.

A local enable freezes the sampled inputs. While it is low, the block reports no new edges. When it returns high, the block resends every lane's current level in the next cycle.

Top module: `iso_edge_tx`

## Requirements
- R1: A level change on `lane_in[i]` shows up as an event on lane i at the third rising clock edge after the input is first sampled. The latency is the same for rising and falling changes, and a pulse of one clock period or longer is carried.
- R2: An event on lane i is a one-cycle pulse on `ev_hi[i]` (lane is now 1) or `ev_lo[i]` (lane is now 0). Both are never asserted together for the same lane.
- R3: While enabled, a non-refresh event fires on lane i exactly when the synchronized level differs from the last level sent for lane i, and carries the synchronized level. No non-refresh event fires otherwise.
- R4: A refresh event is flagged by `ev_refresh[i]` together with an `ev_hi[i]`/`ev_lo[i]` pulse that carries the last level sent. Once a lane has had an event, its next event follows within REFRESH_CYC+LANES-1 cycles.
- R5: At most one bit of `ev_refresh` is set in any cycle.
- R6: An edge event takes priority over a refresh on the same lane and restarts that lane's timer. A refresh therefore comes no sooner than REFRESH_CYC cycles after the lane's previous event.
- R7: While `enable` is low, input changes are ignored and no non-refresh events are produced. Refresh continues with the held level.
- R8: In the cycle after `enable` goes from 0 to 1, every lane emits a non-refresh event carrying its current synchronized level.
- R9: During synchronous reset all outputs are 0, and the sent level of every lane resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Local enable; low freezes the sampled inputs |
| lane_in | input | LANES | Asynchronous lane levels |
| ev_hi | output | LANES | Per-lane set-high event pulse |
| ev_lo | output | LANES | Per-lane set-low event pulse |
| ev_refresh | output | LANES | Marks the event in this cycle as a background refresh |

## Verification
The assertions assume that `enable` is synchronous to `clk` and is held at a known value from time zero, including through reset. The re-enable check also relies on two clean post-reset cycles before a rising enable counts. The stimulus changes `enable` and `lane_in` only on falling clock edges. It keeps `enable` high throughout reset, so the reset state never makes a 0-to-1 enable transition that the checks would misread.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iso_sync2.sv
module iso_sync2 #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/iso_lane_timer.sv
module iso_lane_timer #(
  parameter int unsigned LIMIT = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic due
);
  localparam int unsigned TW = iso_tx_pkg::bits_for(LIMIT);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);
  logic [TW-1:0] cnt;

  assign due = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!due)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/iso_rr_arb.sv
module iso_rr_arb #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int unsigned PW = iso_tx_pkg::bits_for(N);
  localparam logic [PW-1:0] TOP = PW'(N - 1);
  logic [PW-1:0] ptr, pick;
  logic          found;

  always_comb begin
    grant = '0;
    pick  = ptr;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found = 1'b1;
        grant[(int'(ptr) + k) % N] = 1'b1;
        pick = PW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (found) ptr <= (pick == TOP) ? '0 : pick + 1'b1;
  end
endmodule

// File: rtl/iso_edge_tx.sv
module iso_edge_tx #(
  parameter int unsigned LANES       = 5,
  parameter int unsigned REFRESH_CYC = 1250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] ev_hi,
  output logic [LANES-1:0] ev_lo,
  output logic [LANES-1:0] ev_refresh
);
  logic [LANES-1:0] synced, sent, edge_fire, due, grant, restart;
  logic             en_q, reen;

  iso_sync2 #(.W(LANES)) u_sync (
    .clk(clk), .rst(rst), .d(lane_in), .q(synced)
  );

  assign reen      = enable & ~en_q;
  assign edge_fire = !enable ? '0 : (reen ? '1 : (synced ^ sent));
  assign restart   = edge_fire | grant;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iso_lane_timer #(.LIMIT(REFRESH_CYC)) u_tmr (
      .clk(clk), .rst(rst), .restart(restart[g]), .due(due[g])
    );
  end

  iso_rr_arb #(.N(LANES)) u_arb (
    .clk(clk), .rst(rst), .req(due & ~edge_fire), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b1;
      sent       <= '0;
      ev_hi      <= '0;
      ev_lo      <= '0;
      ev_refresh <= '0;
    end else begin
      en_q       <= enable;
      if (enable) sent <= synced;
      ev_hi      <= (edge_fire & synced)  | (grant & sent);
      ev_lo      <= (edge_fire & ~synced) | (grant & ~sent);
      ev_refresh <= grant;
    end
  end
endmodule

// File: rtl/iso_edge_tx_chk.sv
module iso_edge_tx_chk #(
  parameter int unsigned LANES = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [LANES-1:0] lane_in,
  input logic [LANES-1:0] ev_hi,
  input logic [LANES-1:0] ev_lo,
  input logic [LANES-1:0] ev_refresh
);
  AST_NO_DUAL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ev_hi & ev_lo) == '0); // R2

  AST_REFRESH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(ev_refresh) <= 1); // R5

  AST_REFRESH_CARRIES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ev_refresh & ~(ev_hi | ev_lo)) == '0); // R4

  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> ((ev_hi | ev_lo) & ~ev_refresh) == '0); // R7

  AST_REENABLE_ALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable) && !$past(enable, 2))
      |-> ((ev_hi | ev_lo) & ~ev_refresh) == '1); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (ev_hi | ev_lo | ev_refresh) == '0); // R9
endmodule

bind iso_edge_tx iso_edge_tx_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/iso_edge_tx_tb.sv
module iso_edge_tx_tb_top;
  localparam int unsigned L   = 5;
  localparam int unsigned LIM = 40;
  localparam int          MAXGAP = LIM + L - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b1;
  logic [L-1:0] lane_in = '0;
  logic [L-1:0] ev_hi, ev_lo, ev_refresh;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  iso_edge_tx #(.LANES(L), .REFRESH_CYC(LIM)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .lane_in(lane_in),
    .ev_hi(ev_hi), .ev_lo(ev_lo), .ev_refresh(ev_refresh)
  );

  // Reference model built from the requirements
  logic [L-1:0] m_s1, m_s2, m_sent, exp_edge, exp_lvl;
  logic         m_enq, prev_en;
  int           last_ev [L];
  bit           have_last [L];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_en <= enable;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_sent <= '0; m_enq <= 1'b1;
      exp_edge <= '0; exp_lvl <= '0;
    end else begin
      m_s1  <= lane_in;
      m_s2  <= m_s1;
      m_enq <= enable;
      exp_edge <= !enable ? '0 : (!m_enq ? '1 : (m_s2 ^ m_sent));
      exp_lvl  <= m_s2;
      if (enable) m_sent <= m_s2;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      logic [L-1:0] nonref;
      nonref = (ev_hi | ev_lo) & ~ev_refresh;
      chk(nonref == exp_edge, "R3 edge set", nonref, exp_edge);
      chk(((ev_hi & exp_edge) == (exp_lvl & exp_edge)), "R3 edge level", ev_hi & exp_edge, exp_lvl & exp_edge);
      chk((ev_hi & ev_lo) == '0, "R2 exclusive", ev_hi & ev_lo, 0);
      chk($countones(ev_refresh) <= 1, "R5 refresh count", ev_refresh, 0);
      if (!prev_en) chk(nonref == '0, "R7 frozen", nonref, 0);
      for (int i = 0; i < L; i++) begin
        if (ev_refresh[i]) begin
          chk(ev_hi[i] == m_sent[i], "R4 refresh level", ev_hi[i], m_sent[i]);
          if (have_last[i]) begin
            chk(cyc - last_ev[i] >= LIM, "R6 refresh too early", cyc - last_ev[i], LIM);
            chk(cyc - last_ev[i] <= MAXGAP, "R4 refresh late", cyc - last_ev[i], MAXGAP);
          end
        end else if (have_last[i] && !(ev_hi[i] | ev_lo[i]) && cyc - last_ev[i] == MAXGAP + 1) begin
          chk(1'b0, "R4 lane starved", cyc - last_ev[i], MAXGAP);
        end
        if (ev_hi[i] | ev_lo[i]) begin
          last_ev[i] = cyc;
          have_last[i] = 1'b1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd1357);
    for (int i = 0; i < L; i++) begin last_ev[i] = 0; have_last[i] = 1'b0; end
    step(3);
    chk((ev_hi | ev_lo | ev_refresh) == '0, "R9 reset idle", ev_hi | ev_lo | ev_refresh, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    step(1);
    chk((ev_hi | ev_lo) == '0, "R9 sent level zero", ev_hi | ev_lo, 0);
    step(LIM + 2 * L);

    // R1 latency, rising then falling, on lane 2 (quiet instant chosen by waiting)
    for (int pol = 1; pol >= 0; pol--) begin
      lane_in[2] = pol[0];
      step(2);
      chk(!(ev_hi[2] | ev_lo[2]) || ev_refresh[2], "R1 not early", ev_hi[2] | ev_lo[2], 0);
      step(1);
      chk(pol ? ev_hi[2] : ev_lo[2], "R1 third edge", pol ? ev_hi[2] : ev_lo[2], 1);
      chk(!ev_refresh[2], "R6 edge not refresh", ev_refresh[2], 0);
      step(1);
      chk(!(ev_hi[2] | ev_lo[2]), "R2 single pulse", ev_hi[2] | ev_lo[2], 0);
      step(5);
    end

    // one-cycle pulse on lane 4
    lane_in[4] = 1'b1; step(1); lane_in[4] = 1'b0;
    step(2);
    chk(ev_hi[4], "R1 short pulse rise", ev_hi[4], 1);
    step(1);
    chk(ev_lo[4], "R1 short pulse fall", ev_lo[4], 1);

    // quiet stretch: refresh only
    lane_in = 5'b10110;
    step(4 * LIM);

    // disable, wiggle, re-enable
    enable = 1'b0;
    step(1);
    lane_in = 5'b01001;
    step(LIM + 2 * L);
    chk(1'b1, "R7 disable stretch done", 0, 0);
    enable = 1'b1;
    step(1);
    chk(((ev_hi | ev_lo) & ~ev_refresh) == '1, "R8 all lanes resent", (ev_hi | ev_lo) & ~ev_refresh, 5'h1f);
    chk(ev_hi == 5'b01001, "R8 current level", ev_hi, 5'b01001);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 3) == 0) lane_in = lane_in ^ L'(1 << $urandom_range(0, L - 1));
      if ($urandom_range(0, 199) == 0) enable = ~enable;
      if ($urandom_range(0, 999) == 0) step(LIM + L);
      step(1);
    end
    enable = 1'b1;
    step(3 * LIM);

    disable watchdog;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule